// File: doc/BRIEF.md
# One-Time-Programmable Byte Array with Per-Region Locks

This block holds a 1 KiB one-time-programmable byte store. The store is divided into 32 regions of 32 bytes, and the client reaches it through a valid/ready request port that carries a 10-bit byte address, an 8-bit data byte and a read/program select. A read returns the addressed byte one cycle after the request is accepted. A program can only clear bits: the byte that is stored is the old value ANDed with the new value.

Region 0 is special. Its first sixteen bytes carry a factory random number and can never be programmed. Its bytes 0x010 to 0x013 hold one lock bit per region, and its bytes 0x014 to 0x01F are reserved. If a program is refused because it targets protected bytes or a locked region, the array stays unchanged and a one-cycle error pulse is raised. The lock bytes are in region 0, so clearing region 0's own lock bit also freezes every lock bit. A factory-load port writes any byte with no rule applied, so the array can be given its delivery contents.

The controller is a three-state machine. IDLE accepts a request when `req_valid` is high, `load_en` is low and `req_ready` is high. An accepted read moves IDLE to READ, and an accepted program moves IDLE to PROG. READ presents the response, and PROG commits or refuses the program. Both READ and PROG return to IDLE unconditionally on the next edge.

Top module: `otp_lockarray`

## Requirements
- R1: A read accepted at a clock edge gives `rsp_valid`=1 and `rsp_rdata` equal to the stored byte in the following cycle. `req_ready` is low in that cycle and high again in the cycle after it.
- R2: A permitted program stores (old AND new). A bit that is 0 never returns to 1, whatever data is programmed.
- R3: A program to addresses 0x000 to 0x00F (the random-number bytes) leaves the byte unchanged and raises `err_pulse`.
- R4: A program to addresses 0x014 to 0x01F (the reserved bytes) leaves the byte unchanged and raises `err_pulse`.
- R5: The lock bit for region n (addresses n*0x20 to n*0x20+0x1F) is bit n mod 8 of byte 0x010 + n/8. When that bit is 0, a program to the region leaves it unchanged and raises `err_pulse`.
- R6: Once bit 0 of byte 0x010 is 0, programs to bytes 0x010 to 0x013 are refused, so no further lock bit can be cleared.
- R7: Reads are always served, including reads of locked regions, of the random-number bytes and of the reserved bytes.
- R8: `err_pulse` is high for exactly the one cycle that follows the acceptance of a refused program. It stays low after a permitted program and after any read.
- R9: While `load_en` is high, `load_data` is written to `load_addr` with no lock or protection check, and `req_ready` is low.
- R10: After reset, `req_ready` is 1 and both `rsp_valid` and `err_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the controller |
| load_en | input | 1 | Factory-load write strobe |
| load_addr | input | 10 | Factory-load byte address |
| load_data | input | 8 | Factory-load byte value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = program, 0 = read |
| req_addr | input | 10 | Byte address of the request |
| req_wdata | input | 8 | Program data; a 0 bit clears the stored bit |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 8 | Read data, meaningful while rsp_valid is high |
| err_pulse | output | 1 | One-cycle flag for a refused program |

## Verification
The assertions assume two things about the inputs. First, `load_en` is raised only while the controller is in IDLE and no request is pending. Second, a request is held or dropped only at the clock edges where it is sampled. The stimulus meets both assumptions. All factory loading happens before any request is sent or strictly between complete operations. Each request is driven on a falling edge and withdrawn on the next falling edge, which is the cycle in which the response is sampled.

The randomised phase favours region 0 and its lock bytes. That way the lock state changes as the run proceeds, and refused programs and cleared bits turn up alongside permitted programs.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_PROG = 2'd2
    } otp_state_e;

    typedef enum logic [1:0] {
        DENY_NONE = 2'd0,
        DENY_SEED = 2'd1,
        DENY_RSVD = 2'd2,
        DENY_LOCK = 2'd3
    } otp_deny_e;

endpackage

// File: rtl/otp_store.sv
module otp_store #(
    parameter int ADDR_W       = 10,
    parameter int DATA_W       = 8,
    parameter int REGION_BYTES = 32,
    parameter int LOCK_BASE    = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_en,
    input  logic [ADDR_W-1:0]           load_addr,
    input  logic [DATA_W-1:0]           load_data,
    input  logic                        pgm_en,
    input  logic [ADDR_W-1:0]           pgm_addr,
    input  logic [DATA_W-1:0]           pgm_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [DATA_W-1:0]           rd_data,
    output logic [(1<<ADDR_W)/REGION_BYTES-1:0] lock_vec
);
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int REGIONS = DEPTH / REGION_BYTES;

    logic [DATA_W-1:0] mem [DEPTH];

    // Load wins over program; programming only ANDs bits away.
    always_ff @(posedge clk) begin
        if (load_en) begin
            mem[load_addr] <= load_data;
        end else if (pgm_en) begin
            mem[pgm_addr] <= mem[pgm_addr] & pgm_data;
        end
    end

    assign rd_data = mem[rd_addr];

    // Lock bit of region g: bit g mod DATA_W of byte LOCK_BASE + g/DATA_W.
    for (genvar g = 0; g < REGIONS; g++) begin : g_lock
        assign lock_vec[g] = mem[LOCK_BASE + g / DATA_W][g % DATA_W];
    end

    AST_NO_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_en && !load_en) |=> ((mem[$past(pgm_addr)] & ~$past(mem[pgm_addr])) == '0)); // R2

endmodule

// File: rtl/otp_guard.sv
module otp_guard
    import otp_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int DATA_W       = 8,
    parameter int REGION_BYTES = 32,
    parameter int SEED_BYTES   = 16,
    parameter int LOCK_BASE    = 16
) (
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [(1<<ADDR_W)/REGION_BYTES-1:0] lock_vec,
    output logic                                permit
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int REGIONS    = DEPTH / REGION_BYTES;
    localparam int RB_W       = $clog2(REGION_BYTES);
    localparam int LOCK_BYTES = REGIONS / DATA_W;
    localparam int LOCK_END   = LOCK_BASE + LOCK_BYTES;

    otp_deny_e             deny;
    logic [ADDR_W-RB_W-1:0] region;

    assign region = addr[ADDR_W-1:RB_W];

    always_comb begin
        if (addr < ADDR_W'(SEED_BYTES)) begin
            deny = DENY_SEED;
        end else if (addr >= ADDR_W'(LOCK_END) && addr < ADDR_W'(REGION_BYTES)) begin
            deny = DENY_RSVD;
        end else if (!lock_vec[region]) begin
            deny = DENY_LOCK;
        end else begin
            deny = DENY_NONE;
        end
    end

    assign permit = (deny == DENY_NONE);

endmodule

// File: rtl/otp_ctrl.sv
module otp_ctrl
    import otp_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              permit,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              err_pulse,
    output logic              pgm_en,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);
    otp_state_e state_q, state_d;
    logic       accept;

    assign accept = req_valid && req_ready;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = req_write ? ST_PROG : ST_READ;
                end
            end
            ST_READ: state_d = ST_IDLE;
            ST_PROG: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_addr <= '0;
            op_data <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_addr <= req_addr;
                op_data <= req_wdata;
            end
        end
    end

    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        err_pulse = 1'b0;
        pgm_en    = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = !load_en;
            ST_READ: rsp_valid = 1'b1;
            ST_PROG: begin
                pgm_en    = permit;
                err_pulse = !permit;
            end
            default: ;
        endcase
    end

    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> (rsp_valid && !req_ready)); // R1
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R1
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse); // R8
    AST_ERR_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(req_valid && req_ready && req_write)); // R8

endmodule

// File: rtl/otp_lockarray.sv
module otp_lockarray #(
    parameter int ADDR_W       = 10,
    parameter int DATA_W       = 8,
    parameter int REGION_BYTES = 32,
    parameter int SEED_BYTES   = 16,
    parameter int LOCK_BASE    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              err_pulse
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int REGIONS    = DEPTH / REGION_BYTES;
    localparam int RB_W       = $clog2(REGION_BYTES);
    localparam int LOCK_END   = LOCK_BASE + REGIONS / DATA_W;

    logic               pgm_en;
    logic               permit;
    logic [ADDR_W-1:0]  op_addr;
    logic [DATA_W-1:0]  op_data;
    logic [REGIONS-1:0] lock_vec;

    otp_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .permit    (permit),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .err_pulse (err_pulse),
        .pgm_en    (pgm_en),
        .op_addr   (op_addr),
        .op_data   (op_data)
    );

    otp_guard #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REGION_BYTES(REGION_BYTES),
        .SEED_BYTES(SEED_BYTES), .LOCK_BASE(LOCK_BASE)
    ) guard_i (
        .addr     (op_addr),
        .lock_vec (lock_vec),
        .permit   (permit)
    );

    otp_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REGION_BYTES(REGION_BYTES),
        .LOCK_BASE(LOCK_BASE)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_data (load_data),
        .pgm_en    (pgm_en),
        .pgm_addr  (op_addr),
        .pgm_data  (op_data),
        .rd_addr   (op_addr),
        .rd_data   (rsp_rdata),
        .lock_vec  (lock_vec)
    );

    AST_LOCK_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_en |-> lock_vec[op_addr[ADDR_W-1:RB_W]]); // R5
    AST_SEED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_en |-> (op_addr >= ADDR_W'(SEED_BYTES))); // R3
    AST_RSVD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_en |-> !(op_addr >= ADDR_W'(LOCK_END) && op_addr < ADDR_W'(REGION_BYTES))); // R4
    AST_LOAD_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> !req_ready); // R9

endmodule

// File: tb/otp_lockarray_tb.sv
module otp_lockarray_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 1234;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic [9:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_write = 1'b0;
    logic [9:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       rsp_valid;
    logic [7:0] rsp_rdata;
    logic       err_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] mdl [1024];

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_lockarray dut_i (
        .clk(clk), .rst_n(rst_n),
        .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_pulse(err_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic bit allowed(input logic [9:0] a);
        int rg;
        if (a < 10'h010) return 1'b0;
        if (a >= 10'h014 && a < 10'h020) return 1'b0;
        rg = int'(a >> 5);
        return mdl[16 + rg / 8][rg % 8];
    endfunction

    task automatic factory(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        load_en = 1'b1; load_addr = a; load_data = d;
        mdl[a] = d;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid === 1'b1, req, int'(rsp_valid), 1);
        check(rsp_rdata === mdl[a], req, int'(rsp_rdata), int'(mdl[a]));
        check(err_pulse === 1'b0, "R8", int'(err_pulse), 0);
    endtask

    task automatic pg(input logic [9:0] a, input logic [7:0] d, input string req);
        bit ok;
        ok = allowed(a);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check(err_pulse === !ok, req, int'(err_pulse), int'(!ok));
        if (ok) mdl[a] = mdl[a] & d;
        @(negedge clk);
        check(err_pulse === 1'b0, "R8", int'(err_pulse), 0);
        check(req_ready === 1'b1, "R1", int'(req_ready), 1);
    endtask

    initial begin
        void'($urandom(SEED));
        repeat (3) @(negedge clk);
        check(req_ready === 1'b1, "R10", int'(req_ready), 1);
        check(rsp_valid === 1'b0, "R10", int'(rsp_valid), 0);
        check(err_pulse === 1'b0, "R10", int'(err_pulse), 0);
        rst_n = 1'b1;

        // Factory delivery contents: random-number bytes, everything else 0xFF.
        @(negedge clk);
        load_en = 1'b1;
        for (int a = 0; a < 1024; a++) begin
            load_addr = 10'(a);
            load_data = (a < 16) ? 8'(8'hA0 + a) : 8'hFF;
            mdl[a] = load_data;
            if (a == 5) check(req_ready === 1'b0, "R9", int'(req_ready), 0);
            @(negedge clk);
        end
        load_en = 1'b0;

        rd(10'h000, "R7");
        rd(10'h00F, "R7");
        pg(10'h005, 8'h00, "R3");
        rd(10'h005, "R3");
        pg(10'h018, 8'h00, "R4");
        rd(10'h018, "R4");
        pg(10'h040, 8'hF0, "R2");
        rd(10'h040, "R2");
        pg(10'h040, 8'h0F, "R2");
        pg(10'h040, 8'hFF, "R2");
        rd(10'h040, "R2");
        // Lock region 2 via byte 0x010 bit 2, region 31 via byte 0x013 bit 7.
        pg(10'h010, 8'hFB, "R5");
        pg(10'h041, 8'h00, "R5");
        rd(10'h041, "R7");
        pg(10'h013, 8'h7F, "R5");
        pg(10'h3FF, 8'h00, "R5");
        pg(10'h3E0, 8'h00, "R5");
        pg(10'h3C0, 8'h0F, "R5");
        rd(10'h3C0, "R5");

        // Random mix concentrated on region 0 and a few low regions.
        for (int i = 0; i < 400; i++) begin
            logic [9:0] a;
            logic [7:0] d;
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel < 3) a = 10'(16 + $urandom_range(0, 3));
            else if (sel < 5) a = 10'($urandom_range(0, 31));
            else a = 10'($urandom_range(0, 1023));
            if (a >= 10'h010 && a < 10'h014)
                d = ($urandom_range(0, 7) == 0) ? ~(8'h01 << $urandom_range(0, 7)) : 8'hFF;
            else
                d = 8'($urandom);
            if ($urandom_range(0, 1) == 0) pg(a, d, "R5");
            else rd(a, "R1");
        end

        // Region 0 self-lock freezes all lock bytes.
        pg(10'h010, 8'hFE, "R6");
        pg(10'h011, 8'h00, "R6");
        pg(10'h012, 8'h00, "R6");
        rd(10'h011, "R6");

        // Factory load bypasses locks.
        factory(10'h041, 8'h33);
        rd(10'h041, "R9");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule